// File: doc/BRIEF.md
# Address Register Memory Port

This block is the memory side of a stack-oriented core. Loads and stores never take their address from the data stack. The core first copies the data-stack top into a dedicated address register. Every later fetch or store then uses that register. The register keeps its value after an access, so a run of accesses to one location needs only one address load. Post-incrementing variants step the register after the access, which suits walks over consecutive words.

The block holds a synchronous single-port RAM of `DEPTH` words, each `DW` bits wide (18 by default). It takes a 3-bit command each cycle together with the current data-stack top. Results meant for the stack are the fetched word or the address register itself. They appear on a registered push port one cycle after the command. Decoding instructions and keeping the stack are left to the surrounding core.

Top module: `arp_mem_port`

## Requirements
- R1: While `rst` is high at a clock edge, the address register clears to 0 and `push_valid` goes low after that edge.
- R2: Command code 1 (set address) loads the address register with `tos` modulo `DEPTH`, using the low log2(`DEPTH`) bits. It pushes nothing.
- R3: Command code 2 (fetch) presents the RAM word at the address register on `push_data`, with `push_valid` high, in the cycle after the command. The address register is left unchanged.
- R4: Command code 4 (store) writes `tos` into the RAM word at the address register. It pushes nothing and leaves the address register unchanged.
- R5: Command codes 3 (fetch, then step) and 5 (store, then step) behave as codes 2 and 4 but afterwards add one to the address register. From `DEPTH`-1 the register wraps to 0. `DEPTH` must be a power of two.
- R6: Command code 6 (read address) presents the address register, zero-extended to `DW` bits, on `push_data` with `push_valid` high in the following cycle.
- R7: Command codes 0 and 7 change neither the RAM nor the address register, and leave `push_valid` low in the following cycle.
- R8: A store immediately followed by a fetch of the same address returns the value just stored.
- R9: A read-modify-write of one location needs one address load, then a fetch and a store with no reload in between. The fetch returns the old value, and a later fetch returns the new one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| op | input | 3 | Command code for this cycle |
| tos | input | DW | Current data-stack top (address source or store data) |
| push_valid | output | 1 | A word for the data stack is present |
| push_data | output | DW | Word to push (fetched data or address register) |

## Verification
Every command is sampled at one rising edge. Fetched words and the read-back address are due on the push port after that same edge, one cycle later. A new address or a stored word first becomes visible to a command issued in the next cycle. The bench drives each command at a falling edge and updates its behavioural model at the following rising edge. It then compares `push_valid` and `push_data` at the next falling edge, so every result is sampled exactly one cycle after its command. State effects such as loads, increments, wraps and writes are observed through later read-address and fetch commands, and never through internal signals.

// File: rtl/arp_pkg.sv
package arp_pkg;

  typedef enum logic [2:0] {
    OP_IDLE  = 3'd0,
    OP_SETA  = 3'd1,
    OP_LD    = 3'd2,
    OP_LDP   = 3'd3,
    OP_ST    = 3'd4,
    OP_STP   = 3'd5,
    OP_GETA  = 3'd6,
    OP_SPARE = 3'd7
  } arp_op_e;

  function automatic logic op_is_mem_read(arp_op_e o);
    return (o == OP_LD) || (o == OP_LDP);
  endfunction

  function automatic logic op_is_mem_write(arp_op_e o);
    return (o == OP_ST) || (o == OP_STP);
  endfunction

  function automatic logic op_bumps_addr(arp_op_e o);
    return (o == OP_LDP) || (o == OP_STP);
  endfunction

  function automatic logic op_pushes(arp_op_e o);
    return op_is_mem_read(o) || (o == OP_GETA);
  endfunction

endpackage

// File: rtl/arp_addr_reg.sv
module arp_addr_reg #(
  parameter int DEPTH = 64,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load_en,
  input  logic          bump_en,
  input  logic [AW-1:0] load_val,
  output logic [AW-1:0] addr_q
);

  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic [AW-1:0] addr_next;

  always_comb begin
    addr_next = addr_q;
    if (load_en)
      addr_next = load_val;
    else if (bump_en)
      addr_next = (addr_q == LAST) ? '0 : addr_q + AW'(1);
  end

  always_ff @(posedge clk) begin
    if (rst) addr_q <= '0;
    else     addr_q <= addr_next;
  end

  // R1: reset clears the register
  a_r1_addr_reset: assert property (@(posedge clk) rst |=> addr_q == '0);

  // R5: stepping from the top word wraps to zero
  a_r5_wrap: assert property (@(posedge clk) disable iff (rst)
    (bump_en && !load_en && addr_q == LAST) |=> addr_q == '0);

  // R3 / R4: without load or step the address is held
  a_r3_r4_hold: assert property (@(posedge clk) disable iff (rst)
    (!load_en && !bump_en) |=> $stable(addr_q));

endmodule

// File: rtl/arp_ram.sv
module arp_ram #(
  parameter int DW    = 18,
  parameter int DEPTH = 64,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          re,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);

  logic [DW-1:0] store_arr [DEPTH];

  always_ff @(posedge clk) begin
    if (we) store_arr[addr] <= wdata;
    if (re) rdata <= store_arr[addr];
  end

  // read and write are never requested in the same cycle
  a_r3_r4_exclusive: assert property (@(posedge clk) !(re && we));

endmodule

// File: rtl/arp_result.sv
module arp_result #(
  parameter int DW = 18,
  parameter int AW = 6
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          take_ram,
  input  logic          take_addr,
  input  logic [AW-1:0] addr_in,
  input  logic [DW-1:0] ram_q,
  output logic          push_valid,
  output logic [DW-1:0] push_data
);

  localparam int PADW = DW - AW;

  logic          sel_addr_q;
  logic          valid_q;
  logic [AW-1:0] addr_snap_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q     <= 1'b0;
      sel_addr_q  <= 1'b0;
      addr_snap_q <= '0;
    end else begin
      valid_q    <= take_ram | take_addr;
      sel_addr_q <= take_addr;
      if (take_addr) addr_snap_q <= addr_in;
    end
  end

  assign push_valid = valid_q;
  assign push_data  = sel_addr_q ? {{PADW{1'b0}}, addr_snap_q} : ram_q;

  // R1: no push right after reset
  a_r1_no_push: assert property (@(posedge clk) rst |=> !push_valid);

  // R6: read-address returns the register value one cycle later
  a_r6_geta: assert property (@(posedge clk) disable iff (rst)
    take_addr |=> (push_valid && push_data == {{PADW{1'b0}}, $past(addr_in)}));

  // R7: no request, no push
  a_r7_quiet: assert property (@(posedge clk) disable iff (rst)
    (!take_ram && !take_addr) |=> !push_valid);

endmodule

// File: rtl/arp_mem_port.sv
module arp_mem_port #(
  parameter int DW    = 18,
  parameter int DEPTH = 64
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [2:0]    op,
  input  logic [DW-1:0] tos,
  output logic          push_valid,
  output logic [DW-1:0] push_data
);
  import arp_pkg::*;

  localparam int AW = $clog2(DEPTH);

  arp_op_e       cmd;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] ram_q;
  logic          rd_en, wr_en, bump_en, load_en, geta_en;

  assign cmd     = arp_op_e'(op);
  assign rd_en   = op_is_mem_read(cmd);
  assign wr_en   = op_is_mem_write(cmd);
  assign bump_en = op_bumps_addr(cmd);
  assign load_en = (cmd == OP_SETA);
  assign geta_en = (cmd == OP_GETA);

  arp_addr_reg #(.DEPTH(DEPTH), .AW(AW)) u_areg (
    .clk(clk), .rst(rst), .load_en(load_en), .bump_en(bump_en),
    .load_val(tos[AW-1:0]), .addr_q(addr_q)
  );

  arp_ram #(.DW(DW), .DEPTH(DEPTH), .AW(AW)) u_ram (
    .clk(clk), .re(rd_en), .we(wr_en), .addr(addr_q),
    .wdata(tos), .rdata(ram_q)
  );

  arp_result #(.DW(DW), .AW(AW)) u_res (
    .clk(clk), .rst(rst), .take_ram(rd_en), .take_addr(geta_en),
    .addr_in(addr_q), .ram_q(ram_q),
    .push_valid(push_valid), .push_data(push_data)
  );

  // R2: set-address takes tos modulo DEPTH
  a_r2_load: assert property (@(posedge clk) disable iff (rst)
    (cmd == OP_SETA) |=> addr_q == $past(tos[AW-1:0]));

  // R3: a fetch yields a push in the next cycle
  a_r3_fetch_push: assert property (@(posedge clk) disable iff (rst)
    op_is_mem_read(cmd) |=> push_valid);

  // R4: a store pushes nothing
  a_r4_store_silent: assert property (@(posedge clk) disable iff (rst)
    op_is_mem_write(cmd) |=> !push_valid);

endmodule

// File: tb/arp_mem_port_test.sv
module arp_mem_port_test;

  localparam int DW    = 18;
  localparam int DEPTH = 64;

  logic          clk = 1'b0;
  logic          rst;
  logic [2:0]    op;
  logic [DW-1:0] tos;
  logic          push_valid;
  logic [DW-1:0] push_data;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  int model_mem [DEPTH];
  int model_a;
  bit exp_v;
  int exp_d;

  always #5 clk = ~clk;

  arp_mem_port #(.DW(DW), .DEPTH(DEPTH)) uut (
    .clk(clk), .rst(rst), .op(op), .tos(tos),
    .push_valid(push_valid), .push_data(push_data)
  );

  task automatic check(string tag, int act, int expv);
    checks++;
    if (act != expv) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
    end
  endtask

  // called at a falling edge; leaves at the next falling edge after checking
  task automatic step(int code, int data, string tag);
    op  = code[2:0];
    tos = data[DW-1:0];
    @(posedge clk);
    exp_v = (code == 2 || code == 3 || code == 6);
    exp_d = (code == 6) ? model_a : model_mem[model_a];
    if (code == 4 || code == 5) model_mem[model_a] = data & ((1 << DW) - 1);
    if (code == 1) model_a = data % DEPTH;
    else if (code == 3 || code == 5) model_a = (model_a + 1) % DEPTH;
    @(negedge clk);
    check({tag, " valid"}, int'(push_valid), int'(exp_v));
    if (exp_v) check({tag, " data"}, int'(push_data), exp_d);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int lfsr;
    rst = 1'b1; op = 3'd0; tos = '0;
    model_a = 0;
    for (int i = 0; i < DEPTH; i++) model_mem[i] = 0;
    repeat (3) @(negedge clk);
    check("R1 reset valid", int'(push_valid), 0);
    rst = 1'b0;
    step(6, 0, "R1 address after reset");

    // fill every word with stepping stores; the last step wraps
    step(1, 0, "R2 set 0");
    for (int i = 0; i < DEPTH; i++) step(5, (i * 7919 + 3) & 'h3FFFF, "R5 fill");
    step(6, 0, "R5 wrap after fill");
    step(1, 5, "R2 set 5");
    step(2, 0, "R3 fetch");
    step(2, 0, "R3 fetch held addr");
    step(6, 0, "R3 addr unchanged");
    step(3, 0, "R5 fetch step");
    step(3, 0, "R5 fetch step");
    step(6, 0, "R5 after steps");
    step(1, DEPTH - 1, "R2 set top");
    step(3, 0, "R5 fetch at top");
    step(6, 0, "R5 wrap to zero");
    step(1, DEPTH - 1, "R2 set top");
    step(5, 'h2AAAA, "R5 store at top");
    step(6, 0, "R5 store wrap");
    step(1, 'h3FFC5, "R2 wide tos modulo");
    step(6, 0, "R2 readback");
    step(1, 20, "R2 set 20");
    step(4, 'h1234, "R4 store");
    step(6, 0, "R4 addr unchanged");
    step(4, 'h3ABCD, "R8 store");
    step(2, 0, "R8 fetch after store");
    step(1, 10, "R9 set 10");
    step(2, 0, "R9 fetch old");
    step(4, 'h0F0F0, "R9 store new");
    step(2, 0, "R9 fetch new");
    step(0, 'h3FFFF, "R7 idle");
    step(7, 'h3FFFF, "R7 spare");
    step(6, 0, "R7 addr unchanged");
    step(2, 0, "R7 word unchanged");

    lfsr = 'hACE1;
    for (int k = 0; k < 400; k++) begin
      lfsr = ((lfsr >> 1) ^ ((lfsr & 1) ? 'hB400 : 0)) & 'hFFFF;
      step(lfsr % 8, (lfsr * 37) & 'h3FFFF, "R3 R4 R5 mixed");
    end

    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    model_a = 0;
    check("R1 mid-run reset valid", int'(push_valid), 0);
    step(6, 0, "R1 addr after mid-run reset");

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule